// File: doc/BRIEF.md
# Exception Stack-Frame Sequencer

This block carries out the entry half of exception processing for a simple 32-bit CPU core. The core hands it one request that holds a cause code, the status register and program counter as they stood before the fault, the next program counter, the faulting data address, a read/write flag and a 3-bit address-space code. The block raises the status register into supervisor state with tracing off. It fetches the handler address from a vector table whose base comes from a vector base register. It then writes an exception stack frame, one word at a time, below the current supervisor stack pointer. Finally it hands the core a new program counter and a new stack pointer.

Three frame layouts are built. A short four-word frame serves illegal opcodes and privilege violations. A six-word frame also records the address of the faulting instruction. A sixteen-word frame serves bus faults and carries a packed status word describing the failed access. When the core asserts the suppress input with a request, no frame is written and nothing is updated: the block only signals abort, so the core can drop the faulting operation quietly.

All memory traffic goes through one request/acknowledge port. The port stalls for as long as the memory holds off the acknowledge. Requests that arrive while a sequence is running are dropped.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset `busy`, `done`, `abort`, `mem_req`, `sr_we`, `pc_we` and `sp_we` are all 0.
- R2: One cycle after a non-suppressed request is accepted, `sr_we` pulses for one cycle. `sr_out` then equals the request status word with bit 13 (supervisor) forced to 1 and bits 15 and 14 (trace) forced to 0.
- R3: The first memory access of a sequence is a 32-bit read (`mem_we`=0, `mem_wide`=1) at `vbr` + vector×4. The data returned with that acknowledge becomes the handler address.
- R4: Vector choice by `req_cause` (0 illegal, 1 privilege, 2 bus fault, 3 explicit): for an illegal opcode, top nibble 0xA gives 10, 0xF gives 11, and anything else gives 4. Privilege gives 8, bus fault gives 2, and cause 3 takes `req_vec`.
- R5: Every frame word is a write whose address is the stack pointer minus 2 (`mem_wide`=0, data in bits 15:0) or minus 4 (`mem_wide`=1). Address, data and size hold steady until `mem_ack`, and the stack pointer steps only on acknowledge.
- R6: Causes 0 and 1 write, in time order: 16-bit vector offset (vector×4), 32-bit `req_pc`, 16-bit `req_sr`.
- R7: Cause 3 writes, in time order: 32-bit `req_pc`, 16-bit 0x2000|offset, 32-bit `req_next_pc`, 16-bit `req_sr`.
- R8: Cause 2 writes, in time order: three 32-bit zeros, 32-bit `req_fault_addr`, 32-bit zero, 16-bit access status word, 16-bit zero, 16-bit 0xA000|offset, 32-bit `req_pc`, 16-bit `req_sr`.
- R9: The access status word has bit 8 set always, bit 6 set only when `req_is_write` is 0, and `req_fc` in bits 2:0, with every other bit 0. All of it is taken from the request as accepted.
- R10: A request with `req_suppress`=1 makes `done` and `abort` pulse on the next cycle. It causes no memory access and no `sr_we`, `pc_we` or `sp_we`.
- R11: After the last frame write is acknowledged, `done`, `abort`, `pc_we` and `sp_we` pulse together for one cycle. At that pulse `pc_out` holds the handler address and `sp_out` holds the start pointer minus the frame size (8, 12 or 32 bytes).
- R12: `req_valid` while `busy` is 1 is ignored: the running sequence and its frame are unchanged and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request, taken when idle |
| req_cause | input | 2 | Cause code (0 illegal, 1 privilege, 2 bus fault, 3 explicit vector) |
| req_opcode | input | 16 | Opcode of the offending instruction |
| req_vec | input | 8 | Vector number used for cause 3 |
| req_suppress | input | 1 | Abort only, no frame |
| req_sr | input | 16 | Status register before the fault |
| req_pc | input | 32 | Address of the faulting instruction |
| req_next_pc | input | 32 | Address of the following instruction |
| req_fault_addr | input | 32 | Faulting data address |
| req_is_write | input | 1 | 1 when the faulting access was a write |
| req_fc | input | 3 | Address-space code of the faulting access |
| vbr | input | 32 | Vector table base |
| sp_in | input | 32 | Supervisor stack pointer at request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1 for 32-bit, 0 for 16-bit |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data (16-bit items in bits 15:0) |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| sr_we | output | 1 | Status register update strobe |
| sr_out | output | 16 | New status register |
| pc_we | output | 1 | Program counter update strobe |
| pc_out | output | 32 | Handler address |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 32 | Stack pointer after the frame |
| done | output | 1 | Sequence finished |
| abort | output | 1 | Abort the faulting operation |

## Verification
The bench builds the block with its default parameters. These are 32-bit addresses, 8-bit vectors, a 3-bit address-space code, and vector numbers 2, 4, 8, 10 and 11 for the fixed causes. With these settings every frame word is a full-width value, and the vector table lookup and the predecremented addresses can be compared against plain 32-bit arithmetic. The memory model returns a handler derived from the read address and holds off acknowledges for a latency chosen per scenario. This puts both back-to-back writes and long stalls on the same frame within reach.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [1:0] {
      CAUSE_ILLEGAL = 2'd0,
      CAUSE_PRIV    = 2'd1,
      CAUSE_BUSFLT  = 2'd2,
      CAUSE_EXPLICIT = 2'd3
   } cause_e;

   typedef enum logic [1:0] {
      LAYOUT_SHORT = 2'd0,
      LAYOUT_PCREC = 2'd1,
      LAYOUT_BUS   = 2'd2
   } layout_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SUPP  = 3'd1,
      ST_VREAD = 3'd2,
      ST_PUSH  = 3'd3,
      ST_FIN   = 3'd4
   } seq_state_e;

   localparam int unsigned SR_BIT_T1 = 15;
   localparam int unsigned SR_BIT_T0 = 14;
   localparam int unsigned SR_BIT_S  = 13;

   localparam logic [15:0] TAG_PCREC = 16'h2000;
   localparam logic [15:0] TAG_BUS   = 16'hA000;
   localparam logic [15:0] ASW_RERUN = 16'h0100;
   localparam logic [15:0] ASW_READ  = 16'h0040;

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_pkg::*;
#(
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned VEC_BUS     = 2,
   parameter int unsigned VEC_ILLEGAL = 4,
   parameter int unsigned VEC_PRIV    = 8,
   parameter int unsigned VEC_LINE_A  = 10,
   parameter int unsigned VEC_LINE_F  = 11
) (
   input  cause_e             cause,
   input  logic [15:0]        opcode,
   input  logic [VEC_W-1:0]   explicit_vec,
   output logic [VEC_W-1:0]   vec,
   output layout_e            layout
);

   localparam logic [VEC_W-1:0] V_BUS  = VEC_W'(VEC_BUS);
   localparam logic [VEC_W-1:0] V_ILL  = VEC_W'(VEC_ILLEGAL);
   localparam logic [VEC_W-1:0] V_PRIV = VEC_W'(VEC_PRIV);
   localparam logic [VEC_W-1:0] V_LA   = VEC_W'(VEC_LINE_A);
   localparam logic [VEC_W-1:0] V_LF   = VEC_W'(VEC_LINE_F);

   if ((VEC_BUS >> VEC_W) != 0 || (VEC_PRIV >> VEC_W) != 0 ||
       (VEC_ILLEGAL >> VEC_W) != 0 || (VEC_LINE_A >> VEC_W) != 0 ||
       (VEC_LINE_F >> VEC_W) != 0) begin : g_bad_vec
      $error("exc_vector_sel: a fixed vector number does not fit VEC_W");
   end

   logic [VEC_W-1:0] ill_vec;

   always_comb begin
      unique case (opcode[15:12])
         4'hA:    ill_vec = V_LA;
         4'hF:    ill_vec = V_LF;
         default: ill_vec = V_ILL;
      endcase
   end

   always_comb begin
      unique case (cause)
         CAUSE_ILLEGAL: begin vec = ill_vec;      layout = LAYOUT_SHORT; end
         CAUSE_PRIV:    begin vec = V_PRIV;       layout = LAYOUT_SHORT; end
         CAUSE_BUSFLT:  begin vec = V_BUS;        layout = LAYOUT_BUS;   end
         default:       begin vec = explicit_vec; layout = LAYOUT_PCREC; end
      endcase
   end

endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
   import exc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned FC_W   = 3,
   parameter int unsigned IDX_W  = 4
) (
   input  layout_e            layout,
   input  logic [IDX_W-1:0]   idx,
   input  logic [15:0]        saved_sr,
   input  logic [ADDR_W-1:0]  saved_pc,
   input  logic [ADDR_W-1:0]  next_pc,
   input  logic [ADDR_W-1:0]  fault_addr,
   input  logic               is_write,
   input  logic [FC_W-1:0]    fc,
   input  logic [VEC_W-1:0]   vec,
   output logic               item_wide,
   output logic [31:0]        item_data,
   output logic               item_last
);

   logic [15:0] offset;
   logic [15:0] asw;

   assign offset = 16'({vec, 2'b00});
   assign asw    = ASW_RERUN | (is_write ? 16'h0000 : ASW_READ) | 16'(fc);

   // items are listed in the order they are written (highest address first)
   always_comb begin
      item_wide = 1'b0;
      item_data = '0;
      item_last = 1'b0;
      unique case (layout)
         LAYOUT_SHORT: begin
            unique case (idx)
               IDX_W'(0): item_data = 32'(offset);
               IDX_W'(1): begin item_wide = 1'b1; item_data = 32'(saved_pc); end
               default:   begin item_data = 32'(saved_sr); item_last = 1'b1; end
            endcase
         end
         LAYOUT_PCREC: begin
            unique case (idx)
               IDX_W'(0): begin item_wide = 1'b1; item_data = 32'(saved_pc); end
               IDX_W'(1): item_data = 32'(TAG_PCREC | offset);
               IDX_W'(2): begin item_wide = 1'b1; item_data = 32'(next_pc); end
               default:   begin item_data = 32'(saved_sr); item_last = 1'b1; end
            endcase
         end
         default: begin
            unique case (idx)
               IDX_W'(0), IDX_W'(1), IDX_W'(2), IDX_W'(4): item_wide = 1'b1;
               IDX_W'(3): begin item_wide = 1'b1; item_data = 32'(fault_addr); end
               IDX_W'(5): item_data = 32'(asw);
               IDX_W'(6): item_data = '0;
               IDX_W'(7): item_data = 32'(TAG_BUS | offset);
               IDX_W'(8): begin item_wide = 1'b1; item_data = 32'(saved_pc); end
               default:   begin item_data = 32'(saved_sr); item_last = 1'b1; end
            endcase
         end
      endcase
   end

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
   import exc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned FC_W        = 3,
   parameter int unsigned VEC_BUS     = 2,
   parameter int unsigned VEC_ILLEGAL = 4,
   parameter int unsigned VEC_PRIV    = 8,
   parameter int unsigned VEC_LINE_A  = 10,
   parameter int unsigned VEC_LINE_F  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cause,
   input  logic [15:0]       req_opcode,
   input  logic [VEC_W-1:0]  req_vec,
   input  logic              req_suppress,
   input  logic [15:0]       req_sr,
   input  logic [ADDR_W-1:0] req_pc,
   input  logic [ADDR_W-1:0] req_next_pc,
   input  logic [ADDR_W-1:0] req_fault_addr,
   input  logic              req_is_write,
   input  logic [FC_W-1:0]   req_fc,
   input  logic [ADDR_W-1:0] vbr,
   input  logic [ADDR_W-1:0] sp_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              busy,
   output logic              sr_we,
   output logic [15:0]       sr_out,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_out,
   output logic              sp_we,
   output logic [ADDR_W-1:0] sp_out,
   output logic              done,
   output logic              abort
);

   localparam int unsigned MAX_ITEMS = 10;
   localparam int unsigned IDX_W     = $clog2(MAX_ITEMS);

   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("exc_frame_seq: ADDR_W must lie in 16..32");
   end
   if (VEC_W < 2 || VEC_W > 10) begin : g_bad_vecw
      $error("exc_frame_seq: VEC_W must lie in 2..10 so the offset fits 12 bits");
   end
   if (FC_W < 1 || FC_W > 6) begin : g_bad_fc
      $error("exc_frame_seq: FC_W must lie in 1..6 so it stays below the read flag");
   end

   seq_state_e        st_q;
   logic [15:0]       sr_cap_q;
   logic [ADDR_W-1:0] pc_cap_q, npc_cap_q, fa_cap_q, vbr_q, sp_q, handler_q;
   logic              wr_cap_q;
   logic [FC_W-1:0]   fc_cap_q;
   logic [VEC_W-1:0]  vec_q;
   layout_e           layout_q;
   logic [IDX_W-1:0]  idx_q;
   logic              sr_we_q;
   logic [15:0]       sr_new_q;

   logic [VEC_W-1:0]  sel_vec;
   layout_e           sel_layout;
   logic              item_wide, item_last;
   logic [31:0]       item_data;
   logic              accept;
   logic [ADDR_W-1:0] push_addr, vec_addr;

   exc_vector_sel #(
      .VEC_W(VEC_W), .VEC_BUS(VEC_BUS), .VEC_ILLEGAL(VEC_ILLEGAL),
      .VEC_PRIV(VEC_PRIV), .VEC_LINE_A(VEC_LINE_A), .VEC_LINE_F(VEC_LINE_F)
   ) u_vsel (
      .cause        (cause_e'(req_cause)),
      .opcode       (req_opcode),
      .explicit_vec (req_vec),
      .vec          (sel_vec),
      .layout       (sel_layout)
   );

   exc_frame_gen #(
      .ADDR_W(ADDR_W), .VEC_W(VEC_W), .FC_W(FC_W), .IDX_W(IDX_W)
   ) u_fgen (
      .layout     (layout_q),
      .idx        (idx_q),
      .saved_sr   (sr_cap_q),
      .saved_pc   (pc_cap_q),
      .next_pc    (npc_cap_q),
      .fault_addr (fa_cap_q),
      .is_write   (wr_cap_q),
      .fc         (fc_cap_q),
      .vec        (vec_q),
      .item_wide  (item_wide),
      .item_data  (item_data),
      .item_last  (item_last)
   );

   assign accept    = req_valid && (st_q == ST_IDLE);
   assign vec_addr  = vbr_q + ADDR_W'({vec_q, 2'b00});
   assign push_addr = sp_q - (item_wide ? ADDR_W'(4) : ADDR_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         sr_cap_q  <= '0;
         pc_cap_q  <= '0;
         npc_cap_q <= '0;
         fa_cap_q  <= '0;
         wr_cap_q  <= 1'b0;
         fc_cap_q  <= '0;
         vec_q     <= '0;
         layout_q  <= LAYOUT_SHORT;
         vbr_q     <= '0;
         sp_q      <= '0;
         handler_q <= '0;
         idx_q     <= '0;
         sr_we_q   <= 1'b0;
         sr_new_q  <= '0;
      end else begin
         sr_we_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  sr_cap_q  <= req_sr;
                  pc_cap_q  <= req_pc;
                  npc_cap_q <= req_next_pc;
                  fa_cap_q  <= req_fault_addr;
                  wr_cap_q  <= req_is_write;
                  fc_cap_q  <= req_fc;
                  vec_q     <= sel_vec;
                  layout_q  <= sel_layout;
                  vbr_q     <= vbr;
                  sp_q      <= sp_in;
                  idx_q     <= '0;
                  if (req_suppress) begin
                     st_q <= ST_SUPP;
                  end else begin
                     st_q     <= ST_VREAD;
                     sr_we_q  <= 1'b1;
                     sr_new_q <= {1'b0, 1'b0, 1'b1, req_sr[SR_BIT_S-1:0]};
                  end
               end
            end
            ST_VREAD: begin
               if (mem_ack) begin
                  handler_q <= mem_rdata[ADDR_W-1:0];
                  st_q      <= ST_PUSH;
               end
            end
            ST_PUSH: begin
               if (mem_ack) begin
                  sp_q <= push_addr;
                  if (item_last) st_q <= ST_FIN;
                  else           idx_q <= idx_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign mem_req   = (st_q == ST_VREAD) || (st_q == ST_PUSH);
   assign mem_we    = (st_q == ST_PUSH);
   assign mem_wide  = (st_q == ST_PUSH) ? item_wide : 1'b1;
   assign mem_addr  = (st_q == ST_PUSH) ? push_addr : vec_addr;
   assign mem_wdata = (st_q == ST_PUSH) ? item_data : 32'h0;
   assign sr_we     = sr_we_q;
   assign sr_out    = sr_new_q;
   assign pc_we     = (st_q == ST_FIN);
   assign pc_out    = handler_q;
   assign sp_we     = (st_q == ST_FIN);
   assign sp_out    = sp_q;
   assign done      = (st_q == ST_FIN) || (st_q == ST_SUPP);
   assign abort     = done;

   a_r1_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                 && $stable(mem_we) && $stable(mem_wide)));

   a_r5_predecrement: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=>
         (!mem_we || (mem_addr == $past(mem_addr) - (mem_wide ? ADDR_W'(4) : ADDR_W'(2)))));

   a_r10_suppress_only_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_suppress) |=> (done && abort && !pc_we && !sp_we
                                                 && !mem_req && !sr_we));

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_pc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we |-> (done && abort && sp_we && !mem_req));

   a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

endmodule

// File: tb/sim_exc_frame_seq.sv
`timescale 1ns/1ps
module sim_exc_frame_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_cause = '0;
   logic [15:0] req_opcode = '0;
   logic [7:0]  req_vec = '0;
   logic        req_suppress = 1'b0;
   logic [15:0] req_sr = '0;
   logic [31:0] req_pc = '0, req_next_pc = '0, req_fault_addr = '0;
   logic        req_is_write = 1'b0;
   logic [2:0]  req_fc = '0;
   logic [31:0] vbr = '0, sp_in = '0;
   logic        mem_req, mem_we, mem_wide;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ack = 1'b0;
   logic        busy, sr_we, pc_we, sp_we, done, abort;
   logic [15:0] sr_out;
   logic [31:0] pc_out, sp_out;

   always #5 clk = ~clk;

   exc_frame_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
      .req_opcode(req_opcode), .req_vec(req_vec), .req_suppress(req_suppress),
      .req_sr(req_sr), .req_pc(req_pc), .req_next_pc(req_next_pc),
      .req_fault_addr(req_fault_addr), .req_is_write(req_is_write), .req_fc(req_fc),
      .vbr(vbr), .sp_in(sp_in), .mem_req(mem_req), .mem_we(mem_we),
      .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .sr_we(sr_we),
      .sr_out(sr_out), .pc_we(pc_we), .pc_out(pc_out), .sp_we(sp_we),
      .sp_out(sp_out), .done(done), .abort(abort)
   );

   // memory model: handler derived from the read address
   assign mem_rdata = 32'h4000_0000 ^ mem_addr;

   int          lat = 0;
   int          wcnt = 0;
   logic        clr = 1'b1;
   int          log_n = 0;
   logic        log_we [0:31];
   logic        log_wide [0:31];
   logic [31:0] log_addr [0:31];
   logic [31:0] log_data [0:31];
   int          sr_n = 0, pc_n = 0, sp_n = 0, done_n = 0, abort_n = 0;
   logic [15:0] sr_v = '0;
   logic [31:0] pc_v = '0, sp_v = '0;
   int          n_chk = 0, n_err = 0, cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && !mem_ack) begin
         if (wcnt >= lat) begin mem_ack <= 1'b1; wcnt <= 0; end
         else wcnt <= wcnt + 1;
      end else begin
         mem_ack <= 1'b0;
      end
      if (clr) begin
         log_n <= 0; sr_n <= 0; pc_n <= 0; sp_n <= 0; done_n <= 0; abort_n <= 0;
      end else begin
         if (mem_req && mem_ack && log_n < 32) begin
            log_we[log_n]   <= mem_we;
            log_wide[log_n] <= mem_wide;
            log_addr[log_n] <= mem_addr;
            log_data[log_n] <= mem_wdata;
            log_n <= log_n + 1;
         end
         if (sr_we) begin sr_n <= sr_n + 1; sr_v <= sr_out; end
         if (pc_we) begin pc_n <= pc_n + 1; pc_v <= pc_out; end
         if (sp_we) begin sp_n <= sp_n + 1; sp_v <= sp_out; end
         if (done)  done_n <= done_n + 1;
         if (abort) abort_n <= abort_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         finish_run();
      end
   end

   int          e_n;
   logic        e_wide [0:15];
   logic [31:0] e_data [0:15];

   task automatic add(input logic w, input logic [31:0] d);
      e_wide[e_n] = w; e_data[e_n] = d; e_n++;
   endtask

   function automatic logic [7:0] pick_vec(input logic [1:0] c, input logic [15:0] op,
                                           input logic [7:0] v);
      if (c == 2'd1) return 8'd8;
      if (c == 2'd2) return 8'd2;
      if (c == 2'd3) return v;
      if (op[15:12] == 4'hA) return 8'd10;
      if (op[15:12] == 4'hF) return 8'd11;
      return 8'd4;
   endfunction

   task automatic fire(input logic [1:0] c, input logic [15:0] op, input logic [7:0] v,
                       input logic supp, input logic [15:0] sr, input logic [31:0] pc,
                       input logic [31:0] npc, input logic [31:0] fa, input logic wr,
                       input logic [2:0] fc, input logic [31:0] base, input logic [31:0] sp,
                       input int latency, input logic poke_busy);
      @(negedge clk);
      clr = 1'b1;
      lat = latency;
      @(negedge clk);
      clr = 1'b0;
      req_cause = c; req_opcode = op; req_vec = v; req_suppress = supp; req_sr = sr;
      req_pc = pc; req_next_pc = npc; req_fault_addr = fa; req_is_write = wr; req_fc = fc;
      vbr = base; sp_in = sp; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // scramble inputs after acceptance: the frame must use the captured values
      req_sr = 16'h0; req_pc = 32'h0; req_fc = 3'h0; req_is_write = ~wr; sp_in = 32'h0;
      if (poke_busy) begin
         @(negedge clk);
         req_cause = 2'd1; req_suppress = 1'b1; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0; req_suppress = 1'b0;
      end
      for (int i = 0; i < 2000 && done_n == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check_frame(input string tag, input logic [1:0] c, input logic [15:0] op,
                              input logic [7:0] v, input logic [15:0] sr, input logic [31:0] pc,
                              input logic [31:0] npc, input logic [31:0] fa, input logic wr,
                              input logic [2:0] fc, input logic [31:0] base,
                              input logic [31:0] sp);
      logic [7:0]  vec;
      logic [15:0] off;
      logic [31:0] cur, vaddr;
      vec = pick_vec(c, op, v);
      off = {6'd0, vec, 2'b00};
      vaddr = base + {22'd0, vec, 2'b00};
      e_n = 0;
      if (c == 2'd2) begin
         add(1, 0); add(1, 0); add(1, 0); add(1, fa); add(1, 0);
         add(0, {16'd0, 16'h0100 | (wr ? 16'h0 : 16'h0040) | {13'd0, fc}});
         add(0, 0); add(0, {16'd0, 16'hA000 | off}); add(1, pc); add(0, {16'd0, sr});
      end else if (c == 2'd3) begin
         add(1, pc); add(0, {16'd0, 16'h2000 | off}); add(1, npc); add(0, {16'd0, sr});
      end else begin
         add(0, {16'd0, off}); add(1, pc); add(0, {16'd0, sr});
      end
      chk({tag, " R2 sr_we count"}, sr_n, 1);
      chk({tag, " R2 new sr"}, {16'd0, sr_v}, {16'd0, (sr | 16'h2000) & 16'h3FFF});
      chk({tag, " R12 access count"}, log_n, e_n + 1);
      chk({tag, " R3 vector read dir"}, {31'd0, log_we[0]}, 0);
      chk({tag, " R3/R4 vector addr"}, log_addr[0], vaddr);
      cur = sp;
      for (int i = 0; i < e_n && i + 1 < log_n; i++) begin
         cur = cur - (e_wide[i] ? 32'd4 : 32'd2);
         chk($sformatf("%s R5 item %0d addr", tag, i), log_addr[i+1], cur);
         chk($sformatf("%s R5 item %0d size", tag, i), {31'd0, log_wide[i+1]}, {31'd0, e_wide[i]});
         chk($sformatf("%s R6/R7/R8/R9 item %0d data", tag, i), log_data[i+1], e_data[i]);
      end
      chk({tag, " R11 done count"}, done_n, 1);
      chk({tag, " R11 abort count"}, abort_n, 1);
      chk({tag, " R11 pc_we count"}, pc_n, 1);
      chk({tag, " R11 handler"}, pc_v, 32'h4000_0000 ^ vaddr);
      chk({tag, " R11 final sp"}, sp_v, cur);
   endtask

   task automatic t_reset();
      chk("R1 busy", {31'd0, busy}, 0);
      chk("R1 done/abort", {30'd0, done, abort}, 0);
      chk("R1 mem_req", {31'd0, mem_req}, 0);
      chk("R1 strobes", {29'd0, sr_we, pc_we, sp_we}, 0);
   endtask

   task automatic t_short(input logic [1:0] c, input logic [15:0] op, input string tag);
      fire(c, op, 8'd0, 0, 16'hC715, 32'h0000_1234, 32'h0000_1236, 32'h0, 0, 3'd0,
           32'h0000_0400, 32'h0000_8000, 0, 0);
      check_frame(tag, c, op, 8'd0, 16'hC715, 32'h0000_1234, 32'h0000_1236, 32'h0, 0,
                  3'd0, 32'h0000_0400, 32'h0000_8000);
   endtask

   task automatic t_pcrec();
      fire(2'd3, 16'h4E40, 8'd37, 0, 16'h8004, 32'hDEAD_BEE0, 32'hDEAD_BEE4, 32'h0, 0,
           3'd0, 32'h1000_0000, 32'h2000_0100, 1, 0);
      check_frame("R7 explicit", 2'd3, 16'h4E40, 8'd37, 16'h8004, 32'hDEAD_BEE0,
                  32'hDEAD_BEE4, 32'h0, 0, 3'd0, 32'h1000_0000, 32'h2000_0100);
   endtask

   task automatic t_bus(input logic wr, input logic [2:0] fc, input int latency,
                        input string tag);
      fire(2'd2, 16'h0, 8'd0, 0, 16'h2700, 32'h0004_0010, 32'h0, 32'hF800_00A4, wr, fc,
           32'h0, 32'h0001_0000, latency, 0);
      check_frame(tag, 2'd2, 16'h0, 8'd0, 16'h2700, 32'h0004_0010, 32'h0, 32'hF800_00A4,
                  wr, fc, 32'h0, 32'h0001_0000);
   endtask

   task automatic t_suppress();
      fire(2'd2, 16'h0, 8'd0, 1, 16'h0700, 32'h100, 32'h0, 32'h55, 0, 3'd1, 32'h0,
           32'h8000, 0, 0);
      chk("R10 done", done_n, 1);
      chk("R10 abort", abort_n, 1);
      chk("R10 no memory access", log_n, 0);
      chk("R10 no sr_we", sr_n, 0);
      chk("R10 no pc_we/sp_we", pc_n + sp_n, 0);
   endtask

   task automatic t_busy_ignore();
      fire(2'd0, 16'hF123, 8'd0, 0, 16'h0001, 32'h0000_3000, 32'h0, 32'h0, 0, 3'd0,
           32'h0000_0800, 32'h0000_9000, 2, 1);
      check_frame("R12 ignore", 2'd0, 16'hF123, 8'd0, 16'h0001, 32'h0000_3000, 32'h0,
                  32'h0, 0, 3'd0, 32'h0000_0800, 32'h0000_9000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short(2'd0, 16'hA0F3, "R4/R6 line-A");
      t_short(2'd0, 16'hF200, "R4/R6 line-F");
      t_short(2'd0, 16'h4AFC, "R4/R6 illegal");
      t_short(2'd1, 16'h46FC, "R4/R6 privilege");
      t_pcrec();
      t_bus(1'b0, 3'd5, 0, "R8/R9 read fault");
      t_bus(1'b1, 3'd2, 3, "R5/R8/R9 write fault slow");
      t_suppress();
      t_busy_ignore();
      finish_run();
   end

endmodule